// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a single-port synchronous memory meant to sit on a processor bus with very little glue logic. Address, write data, chip selects, burst controls and write enables are all captured on the rising clock edge. Reads are flow-through. The word at the current burst address passes through combinational logic to the read data pins, with no output register. The output enable is asynchronous. A new access can start from a processor-side strobe or from a cache-controller-side strobe. A two-bit burst counter then steps the low address bits, in either linear or interleaved order.

The shared data bus is split at the block edge into `din`, `dout` and a pad driver enable `dout_en`, and the pad ring merges them into one bidirectional bus. When `dout_en` is low, the bus is high impedance. The full product depth is 32K words of 32 bits (`ADDR_W` = 15). The default `ADDR_W` is 10 so that the array stays small when the block is elaborated with its default parameters. Control pins are plain, level-sampled signals with no valid/ready handshake, because the bus protocol has no back-pressure. The first beat of a burst takes two cycles and each later beat takes one, giving a 2-1-1-1 pattern.

Top module: `ft_burst_sram`

## Requirements
- R1: After reset the block is deselected, so `dout_en` is 0 even when `out_en_n` is low.
- R2: A start selects the device only if `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 in that cycle. A deselected access keeps `dout_en` at 0 and writes nothing.
- R3: A start taken from `cpu_strb_n` never writes, whatever the write enables are. A start taken from `ctl_strb_n` writes `din` at the presented address in that same edge when the write enables request it.
- R4: `cpu_strb_n` is ignored while `sel_a_n` is high: the current burst address and selection are kept.
- R5: Flow-through timing. After the edge that takes a start, the word at the presented address appears on `dout` during the following cycle, and each stepped beat appears in the cycle after its edge.
- R6: With `order_sel`=0 (linear), beat k reads address bits [1:0] = (start bits + k) mod 4, and the upper bits are unchanged.
- R7: With `order_sel`=1 (interleaved), beat k reads address bits [1:0] = start bits XOR k, and the upper bits are unchanged.
- R8: In a cycle with no start, `step_n` low advances the burst address. With `step_n` high the address is held, and any write in that cycle goes to the held address.
- R9: The write lane mask is decided as follows. `all_wr_n`=0 writes all four byte lanes. Otherwise, if `byte_wr_en_n`=0, lane i (bits 8i+7..8i) is written when `lane_wr_n[i]`=0. Otherwise nothing is written.
- R10: `dout_en` follows `out_en_n` with no clock edge. It is 1 only while the device is selected, `out_en_n`=0 and `sleep` is 0.
- R11: While `sleep` is high, starts, advances and writes are blocked and `dout_en` is 0. When `sleep` is released, the previous burst address is in place again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| addr | input | ADDR_W | Word address, sampled on a start |
| cpu_strb_n | input | 1 | Processor-side start strobe, active low |
| ctl_strb_n | input | 1 | Controller-side start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Pipelining chip select, active low |
| sel_b | input | 1 | Depth-expansion select, active high |
| sel_c_n | input | 1 | Depth-expansion select, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| byte_wr_en_n | input | 1 | Qualifier for the per-lane enables, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| din | input | LANES*LANE_W | Write data from the shared bus |
| dout | output | LANES*LANE_W | Flow-through read data |
| dout_en | output | 1 | Driver enable for the shared bus |

## Verification
The bench writes and reads back bursts from all four start offsets in both orders. A counter that wrapped past the four-word group, or that added where it should XOR, would return words from the wrong address. It sweeps all sixteen lane masks and tries the qualifier and global-write overrides, so a decoder with swapped priority would corrupt untouched bytes. It also tries a processor-strobe start with writes requested, a processor strobe with the pipelining select high, deselected writes, writes during sleep and a suspended-burst write. Each of these is checked by reading the affected words back: a design that honoured any of the forbidden writes or address loads would return changed data.

// File: rtl/ft_sram_pkg.sv
package ft_sram_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/ft_sram_burst_ctr.sv
module ft_sram_burst_ctr
  import ft_sram_pkg::*;
#(
  parameter int AW     = 10,
  parameter int BEAT_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  input  burst_order_e  order_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] next_o
);
  logic [AW-1:0]     base_q;
  logic [BEAT_W-1:0] cnt_q, cnt_nx, off_cur, off_nx, first;

  assign first  = base_q[BEAT_W-1:0];
  assign cnt_nx = cnt_q + 1'b1;

  always_comb begin
    if (order_i == ORD_XOR) begin
      off_cur = first ^ cnt_q;
      off_nx  = first ^ cnt_nx;
    end else begin
      off_cur = first + cnt_q;
      off_nx  = first + cnt_nx;
    end
  end

  assign addr_o = {base_q[AW-1:BEAT_W], off_cur};
  assign next_o = {base_q[AW-1:BEAT_W], off_nx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      cnt_q  <= '0;
    end else if (step_i) begin
      cnt_q  <= cnt_nx;
    end
  end

  // R5: a load presents the captured address as the first beat
  p_load_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> addr_o == $past(base_i));

  // R6: linear stepping adds one inside the group
  p_linear_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && order_i == ORD_LINEAR) |=>
      (order_i != ORD_LINEAR) ||
      ((addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1)) &&
       (addr_o[AW-1:BEAT_W] == $past(addr_o[AW-1:BEAT_W]))));

  // R7: interleaved stepping changes only the low bits
  p_xor_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && order_i == ORD_XOR) |=>
      (order_i != ORD_XOR) ||
      ((addr_o != $past(addr_o)) &&
       (addr_o[AW-1:BEAT_W] == $past(addr_o[AW-1:BEAT_W]))));

  // R8: no load and no step holds the address
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> !$stable(order_i) || $stable(addr_o));
endmodule

// File: rtl/ft_sram_wr_decode.sv
module ft_sram_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             allow_i,
  input  logic             all_n_i,
  input  logic             qual_n_i,
  input  logic [LANES-1:0] lane_n_i,
  output logic [LANES-1:0] mask_o
);
  always_comb begin
    if (!allow_i)       mask_o = '0;
    else if (!all_n_i)  mask_o = '1;
    else if (!qual_n_i) mask_o = ~lane_n_i;
    else                mask_o = '0;
  end
endmodule

// File: rtl/ft_sram_array.sv
module ft_sram_array #(
  parameter int AW     = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_mask,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we_mask[l]) mem[waddr][l] <= wdata[l*LANE_W +: LANE_W];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ft_burst_sram.sv
module ft_burst_sram
  import ft_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cpu_strb_n,
  input  logic                    ctl_strb_n,
  input  logic                    step_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    all_wr_n,
  input  logic                    byte_wr_en_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    out_en_n,
  input  logic                    sleep,
  input  logic                    order_sel,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DATA_W = LANES * LANE_W;

  logic              cpu_take, start, adv, sel_now, sel_q, wr_ok;
  logic [ADDR_W-1:0] cur_addr, nxt_addr, wr_addr;
  logic [LANES-1:0]  wr_mask;
  logic [DATA_W-1:0] rd_word;
  burst_order_e      order;

  assign order    = burst_order_e'(order_sel);
  assign cpu_take = !cpu_strb_n && !sel_a_n;
  assign start    = !sleep && (cpu_take || !ctl_strb_n);
  assign adv      = !sleep && !start && !step_n;
  assign sel_now  = !sel_a_n && sel_b && !sel_c_n;

  always_comb begin
    if (start)    wr_addr = addr;
    else if (adv) wr_addr = nxt_addr;
    else          wr_addr = cur_addr;
  end

  always_comb begin
    if (sleep)      wr_ok = 1'b0;
    else if (start) wr_ok = !cpu_take && sel_now;
    else            wr_ok = sel_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     sel_q <= 1'b0;
    else if (start) sel_q <= sel_now;
  end

  ft_sram_burst_ctr #(.AW(ADDR_W), .BEAT_W(BEAT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (start),
    .base_i  (addr),
    .step_i  (adv),
    .order_i (order),
    .addr_o  (cur_addr),
    .next_o  (nxt_addr)
  );

  ft_sram_wr_decode #(.LANES(LANES)) u_dec (
    .allow_i  (wr_ok),
    .all_n_i  (all_wr_n),
    .qual_n_i (byte_wr_en_n),
    .lane_n_i (lane_wr_n),
    .mask_o   (wr_mask)
  );

  ft_sram_array #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .we_mask (wr_mask),
    .waddr   (wr_addr),
    .wdata   (din),
    .raddr   (cur_addr),
    .rdata   (rd_word)
  );

  assign dout    = rd_word;
  assign dout_en = sel_q && !out_en_n && !sleep;

  // R11: sleep freezes selection and burst address
  p_sleep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(sel_q) && $stable(cur_addr));

  // R3: a processor-strobe start never writes
  p_cpu_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_take && !sleep) |-> wr_mask == '0);
endmodule

// File: tb/ft_burst_sram_bench.sv
module ft_burst_sram_bench;
  import ft_sram_pkg::*;
  localparam int AW = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cpu_strb_n, ctl_strb_n, step_n, sel_a_n, sel_b, sel_c_n;
  logic all_wr_n, byte_wr_en_n, out_en_n, sleep, order_sel, dout_en;
  logic [3:0]    lane_wr_n;
  logic [AW-1:0] addr;
  logic [31:0]   din, dout;
  logic [31:0]   model [1 << AW];
  int n_chk = 0, n_bad = 0;

  ft_burst_sram u_ft_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strb_n(cpu_strb_n),
    .ctl_strb_n(ctl_strb_n), .step_n(step_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .all_wr_n(all_wr_n), .byte_wr_en_n(byte_wr_en_n),
    .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .sleep(sleep),
    .order_sel(order_sel), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #4;
  endtask

  task automatic idle();
    cpu_strb_n = 1; ctl_strb_n = 1; step_n = 1;
    all_wr_n = 1; byte_wr_en_n = 1; lane_wr_n = '1;
  endtask

  function automatic int baddr(input int base, input int k, input bit ord);
    int lo;
    lo = ord ? ((base & 3) ^ k) : (((base & 3) + k) & 3);
    return (base & ~3) | lo;
  endfunction

  function automatic logic [31:0] pat(input int a, input int s);
    return (32'(a) * 32'h9E3779B1) ^ (32'(s) << 8) ^ 32'h5A;
  endfunction

  task automatic wr_one(input int a, input logic [31:0] d);
    out_en_n = 1; ctl_strb_n = 0; addr = AW'(a); all_wr_n = 0; din = d;
    model[a] = d;
    tick(); idle();
  endtask

  task automatic rd_check(input int a, input string req);
    out_en_n = 0; ctl_strb_n = 0; addr = AW'(a);
    tick(); idle();
    check(dout_en && dout == model[a], req, dout, model[a]);
  endtask

  task automatic wr_burst(input int base, input bit ord, input int seed);
    order_sel = ord; out_en_n = 1;
    for (int k = 0; k < 4; k++) begin
      if (k == 0) begin ctl_strb_n = 0; step_n = 1; addr = AW'(base); end
      else begin ctl_strb_n = 1; step_n = 0; end
      all_wr_n = 0;
      din = pat(baddr(base, k, ord), seed);
      model[baddr(base, k, ord)] = din;
      tick();
    end
    idle();
  endtask

  task automatic rd_burst(input int base, input bit ord, input bit use_cpu);
    int a;
    order_sel = ord; out_en_n = 0; addr = AW'(base);
    if (use_cpu) cpu_strb_n = 0; else ctl_strb_n = 0;
    tick(); idle();
    check(dout_en && dout == model[base], "R5 first beat", dout, model[base]);
    for (int k = 1; k < 4; k++) begin
      step_n = 0;
      tick();
      a = baddr(base, k, ord);
      check(dout == model[a], ord ? "R7 interleaved beat" : "R6 linear beat", dout, model[a]);
    end
    step_n = 1;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, old;
    rst_n = 0; idle(); sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    out_en_n = 0; sleep = 0; order_sel = 0; addr = '0; din = '0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1: deselected after reset
    check(dout_en == 1'b0, "R1 reset deselect", 32'(dout_en), 32'd0);

    // R5/R6/R7: all start offsets, both orders, both strobes
    for (int ord = 0; ord < 2; ord++) begin
      for (int o = 0; o < 4; o++) begin
        wr_burst(32 + 8 * ord + o, ord[0], o + 10 * ord);
        rd_burst(32 + 8 * ord + o, ord[0], o[0]);
      end
    end

    // R9: lane mask sweep
    for (int m = 0; m < 16; m++) begin
      wr_one(64, 32'h1122_3344 + 32'(m));
      d = pat(m, 77);
      out_en_n = 1; ctl_strb_n = 0; addr = AW'(64); byte_wr_en_n = 0;
      lane_wr_n = ~4'(m); din = d;
      for (int l = 0; l < 4; l++) if (m[l]) model[64][8*l +: 8] = d[8*l +: 8];
      tick(); idle();
      rd_check(64, "R9 lane mask");
    end
    // R9: qualifier high blocks lane enables
    out_en_n = 1; ctl_strb_n = 0; addr = AW'(64); lane_wr_n = 4'h0; din = 32'hDEAD_BEEF;
    tick(); idle();
    rd_check(64, "R9 qualifier off");
    // R9: global write overrides lane enables
    out_en_n = 1; ctl_strb_n = 0; addr = AW'(64); all_wr_n = 0; din = 32'hCAFE_0001;
    model[64] = din;
    tick(); idle();
    rd_check(64, "R9 global write");

    // R3: processor-strobe start with writes requested writes nothing
    out_en_n = 1; cpu_strb_n = 0; addr = AW'(33); all_wr_n = 0; din = 32'hBAD0_0003;
    tick(); idle();
    rd_check(33, "R3 cpu start no write");
    // R3: controller-strobe start writes in the same edge
    wr_one(70, 32'h7070_7070);
    rd_check(70, "R3 ctl start write");

    // R8: held address takes the second write
    out_en_n = 1; order_sel = 0; ctl_strb_n = 0; addr = AW'(40); all_wr_n = 0; din = 32'h0808_0001;
    tick();
    ctl_strb_n = 1; step_n = 1; din = 32'h0808_0002; model[40] = din;
    tick(); idle();
    rd_check(40, "R8 suspend write");
    rd_check(41, "R8 neighbour untouched");

    // R4: processor strobe with sel_a_n high is ignored
    out_en_n = 0; ctl_strb_n = 0; addr = AW'(34);
    tick(); idle();
    cpu_strb_n = 0; sel_a_n = 1; addr = AW'(42);
    tick(); idle(); sel_a_n = 0;
    check(dout_en && dout == model[34], "R4 ignored strobe", dout, model[34]);

    // R2: deselected start
    sel_b = 0; ctl_strb_n = 0; addr = AW'(34);
    tick(); idle(); sel_b = 1;
    check(dout_en == 1'b0, "R2 sel_b low", 32'(dout_en), 32'd0);
    sel_c_n = 1; ctl_strb_n = 0; addr = AW'(34); all_wr_n = 0; din = 32'hBAD0_0002;
    tick(); idle(); sel_c_n = 0;
    check(dout_en == 1'b0, "R2 sel_c_n high", 32'(dout_en), 32'd0);
    rd_check(34, "R2 no deselected write");

    // R10: asynchronous output enable
    out_en_n = 1; #1;
    check(dout_en == 1'b0, "R10 oe off", 32'(dout_en), 32'd0);
    out_en_n = 0; #1;
    check(dout_en == 1'b1, "R10 oe on", 32'(dout_en), 32'd1);

    // R11: sleep
    old = model[35];
    sleep = 1; #1;
    check(dout_en == 1'b0, "R11 sleep tristate", 32'(dout_en), 32'd0);
    ctl_strb_n = 0; addr = AW'(35); all_wr_n = 0; din = 32'hBAD0_0011; step_n = 0;
    tick(); idle(); sleep = 0; #1;
    check(dout_en && dout == model[34], "R11 address kept", dout, model[34]);
    rd_check(35, "R11 no write in sleep");
    check(model[35] == old, "R11 model", model[35], old);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule